// File: doc/BRIEF.md
# Asynchronous PROM, I/O and SRAM Access Sequencer

This block carries out one word access at a time to an asynchronous boot PROM, a local I/O device or a static RAM. A bus-side agent presents a request: target area, direction, byte address, transfer size and write data. The sequencer accepts it when idle and then drives the per-area active-low chip selects, the output enable, the write enable and the address and data lines. Every access has a lead-in cycle, a run of programmed wait states, one or more data beats and a lead-out cycle.

Wait states, device width and bus-ready use come from two configuration words. On a device narrower than 32 bits, a read still returns a full word. The block collects it from two halfword beats or four byte beats. The device presents each beat on the low lanes of the input data bus. Writes are single-beat, with big-endian byte enables. A write to the PROM area while the PROM write permission bit is clear is refused with an error pulse and touches no device pin. The reserved area code is refused in the same way.

Top module: `async_mem_seq`

## Requirements
- R1: After reset, busy, done and err are 0, all three chip selects are high, and output enable and write enable are high.
- R2: A read of area code 0 (PROM) gives done in cycle 4 + N after the accepting edge, where N is cfg1[3:0]. This holds for a 32-bit device.
- R3: A write to area 0 gives done in cycle 3 + N, where N is cfg1[7:4]. This holds only when cfg1[11] is 1.
- R4: A write to area 0 while cfg1[11] is 0 gives a single err pulse in cycle 1, with no chip select, output enable or write enable asserted. Area code 3 is refused the same way for both directions.
- R5: Area code 1 (I/O) takes 4 + N cycles for a read and 3 + N for a write, where N is cfg1[23:20].
- R6: Area code 2 (SRAM) takes 4 + N cycles for a read and 3 + N for a write. N is cfg2[1:0] for reads and cfg2[3:2] for writes.
- R7: The width codes are cfg1[9:8] for PROM, cfg1[28:27] for I/O and cfg2[5:4] for SRAM. Code 00 means 8-bit and adds 6 cycles to a read. Code 01 means 16-bit and adds 2 cycles. Code 1x means 32-bit and adds none.
- R8: Narrow read beats are issued at ascending addresses within the word. Byte beats come from mem_din[7:0] and halfword beats from mem_din[15:0]. The first beat lands in the most significant part of rdata, which is valid while done is high.
- R9: When cfg1[26] is set (I/O) or cfg2[7] is set (SRAM), every read beat's second data cycle repeats until mem_ready is high. A write's data cycle does the same. For PROM, or with the enable clear, mem_ready has no effect.
- R10: The selected area's chip select stays low from lead-in until lead-out. The chip select rises in the lead-out cycle, which is also the done cycle. Output enable goes low only in reads and write enable only in writes, never both at once.
- R11: During a write, mem_addr equals the request address and mem_dout equals the write data. mem_ben is 1111 for size 2. For size 1 it is 1100 or 0011 by address bit 1. For size 0 it is 1000 shifted right by the low two address bits.
- R12: A request raised while busy is ignored. No further access or busy follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_area | input | 2 | 0 PROM, 1 I/O, 2 SRAM, 3 reserved |
| req_write | input | 1 | 1 for write |
| req_addr | input | AW | Byte address |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word (writes) |
| req_wdata | input | 32 | Write data |
| cfg1 | input | 32 | PROM and I/O configuration |
| cfg2 | input | 32 | SRAM configuration |
| busy | output | 1 | Access in progress |
| done | output | 1 | Access complete, rdata valid |
| err | output | 1 | Request refused |
| rdata | output | 32 | Assembled read word |
| mem_csn | output | 3 | Active-low chip selects, one per area |
| mem_oen | output | 1 | Active-low output enable |
| mem_wen | output | 1 | Active-low write enable |
| mem_addr | output | AW | Device address |
| mem_ben | output | 4 | Byte enables for writes |
| mem_dout | output | 32 | Device write data |
| mem_din | input | 32 | Device read data |
| mem_ready | input | 1 | Device ready |

## Verification
A wrong wait-state load or beat count moves the done pulse off its predicted cycle. This shows on the first access to the area concerned. A wrong beat address or assembly order corrupts rdata in that same done cycle, because the bench's device returns address-dependent data. A stuck ready gate either hangs the access or ends it early. The bench drives ready low for a chosen number of cycles and sees the done cycle shift, or fail to shift, within that window.

// File: rtl/async_mem_seq.sv
module async_mem_seq #(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_area,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic [31:0]   req_wdata,
  input  logic [31:0]   cfg1,
  input  logic [31:0]   cfg2,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [31:0]   rdata,
  output logic [2:0]    mem_csn,
  output logic          mem_oen,
  output logic          mem_wen,
  output logic [AW-1:0] mem_addr,
  output logic [3:0]    mem_ben,
  output logic [31:0]   mem_dout,
  input  logic [31:0]   mem_din,
  input  logic          mem_ready
);
  localparam int NAREA = 3;

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_WAIT, S_D1, S_D2, S_WDATA, S_OUT, S_ERR} st_t;
  st_t st;

  logic [1:0]    area_q, size_q, width_q, beat_q;
  logic          wr_q, rdy_en_q;
  logic [3:0]    cnt_q;
  logic [AW-1:0] addr_q;
  logic [31:0]   wdata_q, rdata_q;

  logic [1:0] sel_width;
  logic [3:0] sel_ws;
  logic       sel_rdy;

  always_comb begin
    case (req_area)
      2'd0: begin
        sel_width = cfg1[9:8];
        sel_ws    = req_write ? cfg1[7:4] : cfg1[3:0];
        sel_rdy   = 1'b0;
      end
      2'd1: begin
        sel_width = cfg1[28:27];
        sel_ws    = cfg1[23:20];
        sel_rdy   = cfg1[26];
      end
      default: begin
        sel_width = cfg2[5:4];
        sel_ws    = {2'b00, req_write ? cfg2[3:2] : cfg2[1:0]};
        sel_rdy   = cfg2[7];
      end
    endcase
  end

  wire reject    = (req_area == 2'd3) || (req_area == 2'd0 && req_write && !cfg1[11]);
  wire accept    = req_valid && st == S_IDLE;
  wire rdy_ok    = !rdy_en_q || mem_ready;
  wire [1:0] last_beat = width_q[1] ? 2'd0 : (width_q[0] ? 2'd1 : 2'd3);
  wire st_t after_wait = st_t'(wr_q ? S_WDATA : S_D1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      area_q   <= '0;
      size_q   <= '0;
      width_q  <= '0;
      beat_q   <= '0;
      wr_q     <= 1'b0;
      rdy_en_q <= 1'b0;
      cnt_q    <= '0;
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          area_q   <= req_area;
          wr_q     <= req_write;
          addr_q   <= req_addr;
          size_q   <= req_size;
          wdata_q  <= req_wdata;
          width_q  <= sel_width;
          cnt_q    <= sel_ws;
          rdy_en_q <= sel_rdy;
          beat_q   <= '0;
          st       <= reject ? S_ERR : S_LEAD;
        end
        S_LEAD: st <= (cnt_q != 0) ? S_WAIT : after_wait;
        S_WAIT: begin
          cnt_q <= cnt_q - 4'd1;
          if (cnt_q == 4'd1) st <= after_wait;
        end
        S_D1: st <= S_D2;
        S_D2: if (rdy_ok) begin
          case (width_q)
            2'b00:   rdata_q <= {rdata_q[23:0], mem_din[7:0]};
            2'b01:   rdata_q <= {rdata_q[15:0], mem_din[15:0]};
            default: rdata_q <= mem_din;
          endcase
          if (beat_q == last_beat) st <= S_OUT;
          else begin
            beat_q <= beat_q + 2'd1;
            st     <= S_D1;
          end
        end
        S_WDATA: if (rdy_ok) st <= S_OUT;
        default: st <= S_IDLE;
      endcase
    end
  end

  wire cs_act = (st == S_LEAD) || (st == S_WAIT) || (st == S_D1) || (st == S_D2) || (st == S_WDATA);

  for (genvar i = 0; i < NAREA; i++) begin : g_cs
    assign mem_csn[i] = !(cs_act && area_q == 2'(i));
  end

  wire [1:0] rd_off = width_q[1] ? 2'b00 : (width_q[0] ? {beat_q[0], 1'b0} : beat_q);

  assign mem_oen  = !(!wr_q && (st == S_WAIT || st == S_D1 || st == S_D2));
  assign mem_wen  = !(wr_q && (st == S_WAIT || st == S_WDATA));
  assign mem_addr = wr_q ? addr_q : {addr_q[AW-1:2], rd_off};
  assign mem_dout = wdata_q;
  assign mem_ben  = (size_q == 2'd0) ? (4'b1000 >> addr_q[1:0]) :
                    (size_q == 2'd1) ? (addr_q[1] ? 4'b0011 : 4'b1100) : 4'b1111;
  assign busy  = st != S_IDLE;
  assign done  = st == S_OUT;
  assign err   = st == S_ERR;
  assign rdata = rdata_q;

  // R10
  cs_single_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~mem_csn));
  // R10
  oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(!mem_oen && !mem_wen));
  // R10
  cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> &mem_csn);
  // R4
  prom_wr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && req_area == 2'd0 && req_write && !cfg1[11]) |=> (err && &mem_csn && mem_wen));
  // R12
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && !busy) |=> busy);
  // R9
  ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_wen && $past(!mem_wen) && !mem_ready && rdy_en_q) |=> !done);
endmodule

// File: tb/test_async_mem_seq.sv
module test_async_mem_seq;
  localparam int AW = 24;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, mem_ready = 1'b1;
  logic [1:0] req_area = '0, req_size = '0, cur_w = 2'b10;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0, cfg1 = '0, cfg2 = '0;
  logic busy, done, err, mem_oen, mem_wen;
  logic [31:0] rdata, mem_dout, mem_din;
  logic [2:0] mem_csn;
  logic [AW-1:0] mem_addr;
  logic [3:0] mem_ben;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  function automatic logic [31:0] dev(input logic [AW-1:0] a);
    return (32'(a) * 32'h0100_0193) ^ 32'h5A5A_3C3C;
  endfunction

  assign mem_din = (cur_w == 2'b00) ? {24'h0, dev(mem_addr)[7:0]} :
                   (cur_w == 2'b01) ? {16'h0, dev(mem_addr)[15:0]} : dev(mem_addr);

  async_mem_seq #(.AW(AW)) i_async_mem_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_area(req_area), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata), .cfg1(cfg1), .cfg2(cfg2),
    .busy(busy), .done(done), .err(err), .rdata(rdata), .mem_csn(mem_csn), .mem_oen(mem_oen),
    .mem_wen(mem_wen), .mem_addr(mem_addr), .mem_ben(mem_ben), .mem_dout(mem_dout),
    .mem_din(mem_din), .mem_ready(mem_ready));

  task automatic chk(input string tag, input logic ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] a_width(input logic [1:0] a, input logic [31:0] c1, input logic [31:0] c2);
    return (a == 0) ? c1[9:8] : (a == 1) ? c1[28:27] : c2[5:4];
  endfunction

  function automatic int exp_cyc(input logic [1:0] a, input logic w, input logic [31:0] c1,
                                 input logic [31:0] c2, input int rdy_at);
    int ws, c, nb;
    logic re;
    logic [1:0] wd;
    wd = a_width(a, c1, c2);
    ws = (a == 0) ? int'(w ? c1[7:4] : c1[3:0]) : (a == 1) ? int'(c1[23:20]) : int'(w ? c2[3:2] : c2[1:0]);
    re = (a == 1) ? c1[26] : (a == 2) ? c2[7] : 1'b0;
    nb = wd[1] ? 1 : (wd[0] ? 2 : 4);
    c = 1 + ws;
    if (w) begin
      c++;
      while (re && c < rdy_at) c++;
    end else begin
      for (int b = 0; b < nb; b++) begin
        c += 2;
        while (re && c < rdy_at) c++;
      end
    end
    return c + 1;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [AW-1:0] a, input logic [1:0] wd);
    logic [AW-1:0] base;
    base = {a[AW-1:2], 2'b00};
    if (wd[1]) return dev(base);
    if (wd[0]) return {dev(base)[15:0], dev(base | 2)[15:0]};
    return {dev(base)[7:0], dev(base | 1)[7:0], dev(base | 2)[7:0], dev(base | 3)[7:0]};
  endfunction

  function automatic logic [3:0] exp_ben(input logic [AW-1:0] a, input logic [1:0] s);
    if (s == 0) return 4'b1000 >> a[1:0];
    if (s == 1) return a[1] ? 4'b0011 : 4'b1100;
    return 4'b1111;
  endfunction

  function automatic string tag_of(input logic [1:0] a, input logic w);
    if (a == 0) return w ? "R3" : "R2";
    return (a == 1) ? "R5" : "R6";
  endfunction

  int cyc;
  logic [31:0] rd;
  logic cs_ok, saw_oe, saw_we, wr_ok, got_err;
  logic [3:0] ben;

  task automatic run_access(input logic [1:0] a, input logic w, input logic [AW-1:0] ad,
                            input logic [1:0] sz, input logic [31:0] wd, input int rdy_at, input int poke_at);
    @(negedge clk);
    cur_w = a_width(a, cfg1, cfg2);
    req_area = a; req_write = w; req_addr = ad; req_size = sz; req_wdata = wd;
    req_valid = 1'b1;
    mem_ready = (0 >= rdy_at);
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 1; rd = '0; cs_ok = 1'b1; saw_oe = 1'b0; saw_we = 1'b0; wr_ok = 1'b1; got_err = 1'b0; ben = '0;
    forever begin
      mem_ready = (cyc >= rdy_at);
      if (cyc == poke_at) begin
        req_valid = 1'b1; req_area = 2'd2; req_write = 1'b0;
      end else req_valid = 1'b0;
      #1;
      if (mem_csn != ((done || err) ? 3'b111 : ~(3'b001 << a))) cs_ok = 1'b0;
      if (!mem_oen) saw_oe = 1'b1;
      if (!mem_wen) begin
        saw_we = 1'b1;
        ben = mem_ben;
        if (mem_addr != ad || mem_dout != wd) wr_ok = 1'b0;
      end
      if (done) begin rd = rdata; break; end
      if (err) begin got_err = 1'b1; break; end
      if (cyc > 400) break;
      cyc++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    mem_ready = 1'b1;
  endtask

  task automatic check_access(input logic [1:0] a, input logic w, input logic [AW-1:0] ad,
                              input logic [1:0] sz, input logic [31:0] wd, input int rdy_at, input string t);
    int ec;
    ec = exp_cyc(a, w, cfg1, cfg2, rdy_at);
    run_access(a, w, ad, sz, wd, rdy_at, 0);
    chk({t, " cycles"}, cyc == ec && !got_err, cyc, ec);
    chk("R10 strobes", cs_ok && saw_oe == !w && saw_we == w, {cs_ok, saw_oe, saw_we}, {1'b1, !w, w});
    if (w) begin
      chk("R11 write lanes", wr_ok && ben == exp_ben(ad, sz), {wr_ok, ben}, {1'b1, exp_ben(ad, sz)});
    end else begin
      chk("R8 read data", rd == exp_rd(ad, a_width(a, cfg1, cfg2)), rd, exp_rd(ad, a_width(a, cfg1, cfg2)));
    end
  endtask

  initial begin
    int wdg = 0;
    forever begin
      @(posedge clk);
      wdg++;
      if (wdg > 150000) begin
        fails++;
        $display("FAIL R12 watchdog actual=%0d expected=<150000", wdg);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd2718));
    #1;
    // R1
    chk("R1 reset", !busy && !done && !err && mem_csn == 3'b111 && mem_oen && mem_wen,
        {busy, done, err, mem_csn, mem_oen, mem_wen}, 8'b000_111_11);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", !busy && mem_csn == 3'b111, {busy, mem_csn}, 4'b0111);

    // R2 PROM read, 32-bit, 0 and 15 wait states
    cfg1 = 32'h0000_0200; cfg2 = 32'h0000_0020;
    check_access(2'd0, 1'b0, 24'h001230, 2'd2, 0, 0, "R2");
    cfg1 = 32'h0000_020F;
    check_access(2'd0, 1'b0, 24'h001234, 2'd2, 0, 0, "R2");
    // R3 PROM write permitted
    cfg1 = 32'h0000_0A50;
    check_access(2'd0, 1'b1, 24'h000102, 2'd1, 32'hCAFE_F00D, 0, "R3");
    // R4 PROM write refused
    cfg1 = 32'h0000_0250;
    run_access(2'd0, 1'b1, 24'h000100, 2'd2, 32'h1, 0, 0);
    chk("R4 prom write refused", got_err && cyc == 1 && cs_ok && !saw_we && !saw_oe,
        {got_err, cyc[3:0], saw_we}, {1'b1, 4'd1, 1'b0});
    run_access(2'd3, 1'b0, 24'h000100, 2'd2, 32'h1, 0, 0);
    chk("R4 reserved area refused", got_err && cyc == 1 && !saw_oe, {got_err, cyc[3:0]}, {1'b1, 4'd1});
    // R7 narrow reads without wait states
    cfg1 = 32'h0000_0000;
    check_access(2'd0, 1'b0, 24'h000040, 2'd2, 0, 0, "R7 8-bit 10 cycles");
    cfg1 = 32'h0000_0100;
    check_access(2'd0, 1'b0, 24'h000082, 2'd2, 0, 0, "R7 16-bit 6 cycles");
    // R5 I/O read and write
    cfg1 = 32'h1030_0000;
    check_access(2'd1, 1'b0, 24'h200010, 2'd2, 0, 0, "R5");
    check_access(2'd1, 1'b1, 24'h200013, 2'd0, 32'h0000_00AB, 0, "R5");
    // R6 SRAM maximum wait states
    cfg2 = 32'h0000_002F;
    check_access(2'd2, 1'b0, 24'h400000, 2'd2, 0, 0, "R6");
    check_access(2'd2, 1'b1, 24'h400004, 2'd2, 32'h1234_5678, 0, "R6");
    // R9 ready stretch for I/O read and SRAM write, ignored when disabled and for PROM
    cfg1 = 32'h1400_0000;
    check_access(2'd1, 1'b0, 24'h200020, 2'd2, 0, 9, "R9 I/O stretch");
    cfg2 = 32'h00A0;
    check_access(2'd2, 1'b1, 24'h400010, 2'd2, 32'h55AA_55AA, 7, "R9 SRAM stretch");
    cfg1 = 32'h1000_0000;
    run_access(2'd1, 1'b0, 24'h200020, 2'd2, 0, 9, 0);
    chk("R9 ready ignored when disabled", cyc == 4, cyc, 4);
    cfg1 = 32'h0400_0200;
    run_access(2'd0, 1'b0, 24'h000020, 2'd2, 0, 9, 0);
    chk("R9 ready ignored for PROM", cyc == 4, cyc, 4);
    // R12 request while busy
    cfg1 = 32'h0000_0205;
    run_access(2'd0, 1'b0, 24'h000500, 2'd2, 0, 0, 3);
    chk("R12 first access completes", cyc == 9, cyc, 9);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R12 busy request ignored", !busy && mem_csn == 3'b111, {busy, mem_csn}, 4'b0111);
    end

    // random mix
    for (int n = 0; n < 150; n++) begin
      logic [1:0] a;
      logic w;
      int ra;
      a = 2'($urandom % 3);
      w = 1'($urandom);
      cfg1 = $urandom | 32'h0000_0800;
      cfg2 = $urandom;
      ra = (a != 0 && ($urandom % 3) == 0) ? int'($urandom % 24) : 0;
      check_access(a, w, AW'($urandom), 2'($urandom % 3), $urandom, ra, tag_of(a, w));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule